// File: doc/BRIEF.md
# Temperature-Indexed Lookup Address Generator

The block turns a signed temperature reading into entry numbers for two calibration tables and returns the entries stored there. One table is a fine-grained modulation table with one entry per 2 °C. The other is a coarser tracking-error table with one entry per 4 °C. The tracking-error entry sets the automatic power control setpoint, so that setpoint follows temperature. Both tables start at -40 °C. A reading outside a table's span selects that table's first or last entry.

A one-cycle `sample_stb` starts a fetch. The two indices are computed in the strobe cycle and the two small RAMs are read at the next clock edge. The two bytes, with their indices, are then presented under a one-cycle `out_valid` pulse. Fetches may be issued on every cycle. The tables are loaded through a byte write port. This port acts only while a privileged-access qualifier is asserted.

Top module: `tlut_addr_gen`

## Requirements
- R1: With W = floor(temp_in / 256), where temp_in is two's complement with 1/256 °C per LSB, the modulation index is floor((W + 40) / 2) whenever that value lies within 0..71.
- R2: The tracking-error index is floor((W + 40) / 4) whenever that value lies within 0..35.
- R3: For W below -40, both indices are 0. This includes fractional readings just under -40 °C, such as -40.004 °C.
- R4: For W of 104 or more, the modulation index is 71 and the tracking-error index is 35. A W of 102 or 103 gives modulation index 71, and a W of 100 to 103 gives tracking-error index 35.
- R5: If `sample_stb` is high in cycle c, `out_valid` is high in cycle c+2. `out_valid` is low in every cycle whose cycle c-2 had no strobe.
- R6: While `out_valid` is high, `mod_val` and `te_val` equal the stored entries at `mod_idx` and `te_idx`, and those indices are the ones computed from the strobed temperature.
- R7: A write with `wr_en` and `wr_unlock` both high stores `wr_data` at entry `wr_addr` of the table chosen by `wr_sel` (0 = modulation, 1 = tracking error). If `wr_unlock` is low, the write is ignored.
- R8: A write issued in the strobe cycle or later does not change that fetch's values. A write issued before the strobe cycle is seen by the fetch.
- R9: While `out_valid` is low, `mod_idx`, `te_idx`, `mod_val` and `te_val` hold their last presented values.
- R10: While `rst` is high and after it falls, `out_valid` is 0 and all index and value outputs are 0 until the first fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | New temperature sample; starts a fetch |
| temp_in | input | 16 | Signed temperature, 1/256 °C per LSB |
| wr_en | input | 1 | Table write request |
| wr_unlock | input | 1 | Privileged access granted; writes act only when high |
| wr_sel | input | 1 | Table select: 0 modulation, 1 tracking error |
| wr_addr | input | 7 | Entry number to write |
| wr_data | input | 8 | Entry value to write |
| mod_idx | output | 7 | Modulation index of the last fetch |
| te_idx | output | 6 | Tracking-error index of the last fetch |
| mod_val | output | 8 | Modulation entry of the last fetch |
| te_val | output | 8 | Tracking-error entry (setpoint) of the last fetch |
| out_valid | output | 1 | One-cycle pulse marking a completed fetch |

## Verification
A faulty pipeline flag shows up as a missing, doubled or shifted `out_valid` pulse, which the bench sees in the second cycle after the strobe. A wrong index or clamp appears at the same cycle, in `mod_idx` or `te_idx` at the temperatures around a window edge or a range limit. A corrupted table entry, a write applied while locked, or a read that sees a write made in the strobe cycle shows up only when a later fetch lands on that entry, so the bench places its fetches on the entries it has just written. Because the outputs must hold between pulses, any spurious update is caught on the very cycle after it happens.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
  typedef enum logic {TBL_MOD = 1'b0, TBL_TE = 1'b1} tbl_sel_e;

  // number of table entries needed to span [lo, hi] degrees in 2**shift steps
  function automatic int span_entries(int lo_deg, int hi_deg, int shift);
    return ((hi_deg - lo_deg) >> shift) + 1;
  endfunction
endpackage

// File: rtl/tlut_index.sv
module tlut_index #(
  parameter int TEMP_W = 16,
  parameter int FRAC_W = 8,
  parameter int BASE   = -40,
  parameter int SHIFT  = 1,
  parameter int DEPTH  = 72,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic signed [TEMP_W-1:0] temp,
  output logic [IDX_W-1:0]         idx
);
  localparam int INT_W = TEMP_W - FRAC_W;
  localparam int D_W   = INT_W + 2;
  localparam logic signed [D_W-1:0] LAST = D_W'(DEPTH - 1);

  logic signed [INT_W-1:0] whole;
  logic signed [D_W-1:0]   delta;
  logic signed [D_W-1:0]   step;

  assign whole = temp[TEMP_W-1:FRAC_W];
  assign delta = D_W'(whole) - D_W'(BASE);
  assign step  = delta >>> SHIFT;

  always_comb begin
    if (delta < 0)
      idx = '0;
    else if (step > LAST)
      idx = IDX_W'(DEPTH - 1);
    else
      idx = step[IDX_W-1:0];
  end
endmodule

// File: rtl/tlut_ram.sv
module tlut_ram #(
  parameter int DEPTH  = 72,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first: a same-edge write is not seen by this read
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlut_addr_gen.sv
module tlut_addr_gen #(
  parameter int TEMP_W    = 16,
  parameter int FRAC_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_DEG  = -40,
  parameter int MOD_SHIFT = 1,
  parameter int MOD_DEPTH = tlut_pkg::span_entries(-40, 102, 1),
  parameter int TE_SHIFT  = 2,
  parameter int TE_DEPTH  = 36,
  parameter int MOD_IW    = $clog2(MOD_DEPTH),
  parameter int TE_IW     = $clog2(TE_DEPTH),
  parameter int ADDR_W    = (MOD_IW > TE_IW) ? MOD_IW : TE_IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              wr_en,
  input  logic              wr_unlock,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [MOD_IW-1:0] mod_idx,
  output logic [TE_IW-1:0]  te_idx,
  output logic [DATA_W-1:0] mod_val,
  output logic [DATA_W-1:0] te_val,
  output logic              out_valid
);
  import tlut_pkg::*;

  localparam int INT_W    = TEMP_W - FRAC_W;
  localparam int MOD_HIGH = BASE_DEG + (MOD_DEPTH << MOD_SHIFT);
  localparam int TE_HIGH  = BASE_DEG + (TE_DEPTH << TE_SHIFT);
  localparam logic [MOD_IW-1:0] MOD_LAST = MOD_IW'(MOD_DEPTH - 1);
  localparam logic [TE_IW-1:0]  TE_LAST  = TE_IW'(TE_DEPTH - 1);

  logic [MOD_IW-1:0] mod_idx_c, mod_idx_p;
  logic [TE_IW-1:0]  te_idx_c, te_idx_p;
  logic [DATA_W-1:0] mod_rd, te_rd;
  logic              fetch_v;
  logic              mod_we, te_we;
  tbl_sel_e          sel;
  logic signed [INT_W-1:0] temp_whole;

  assign sel        = tbl_sel_e'(wr_sel);
  assign temp_whole = temp_in[TEMP_W-1:FRAC_W];

  tlut_index #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .BASE(BASE_DEG),
    .SHIFT(MOD_SHIFT), .DEPTH(MOD_DEPTH), .IDX_W(MOD_IW)
  ) u_mod_index (
    .temp(temp_in), .idx(mod_idx_c)
  );

  tlut_index #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .BASE(BASE_DEG),
    .SHIFT(TE_SHIFT), .DEPTH(TE_DEPTH), .IDX_W(TE_IW)
  ) u_te_index (
    .temp(temp_in), .idx(te_idx_c)
  );

  assign mod_we = wr_en && wr_unlock && (sel == TBL_MOD) &&
                  (int'(wr_addr) < MOD_DEPTH);
  assign te_we  = wr_en && wr_unlock && (sel == TBL_TE) &&
                  (int'(wr_addr) < TE_DEPTH);

  tlut_ram #(.DEPTH(MOD_DEPTH), .DATA_W(DATA_W), .AW(MOD_IW)) u_mod_ram (
    .clk(clk), .we(mod_we), .waddr(wr_addr[MOD_IW-1:0]), .wdata(wr_data),
    .raddr(mod_idx_c), .rdata(mod_rd)
  );

  tlut_ram #(.DEPTH(TE_DEPTH), .DATA_W(DATA_W), .AW(TE_IW)) u_te_ram (
    .clk(clk), .we(te_we), .waddr(wr_addr[TE_IW-1:0]), .wdata(wr_data),
    .raddr(te_idx_c), .rdata(te_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_v   <= 1'b0;
      mod_idx_p <= '0;
      te_idx_p  <= '0;
      out_valid <= 1'b0;
      mod_idx   <= '0;
      te_idx    <= '0;
      mod_val   <= '0;
      te_val    <= '0;
    end else begin
      fetch_v   <= sample_stb;
      out_valid <= fetch_v;
      if (sample_stb) begin
        mod_idx_p <= mod_idx_c;
        te_idx_p  <= te_idx_c;
      end
      if (fetch_v) begin
        mod_idx <= mod_idx_p;
        te_idx  <= te_idx_p;
        mod_val <= mod_rd;
        te_val  <= te_rd;
      end
    end
  end

  // R5
  valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> ##1 out_valid);

  // R5
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ##1 !out_valid);

  // R3
  low_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && temp_whole < BASE_DEG) |=> ##1 (mod_idx == '0 && te_idx == '0));

  // R4
  high_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && temp_whole >= MOD_HIGH && temp_whole >= TE_HIGH)
      |=> ##1 (mod_idx == MOD_LAST && te_idx == TE_LAST));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(mod_val) && $stable(te_val) &&
                    $stable(mod_idx) && $stable(te_idx)));
endmodule

// File: tb/tlut_addr_gen_test.sv
module tlut_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_stb = 1'b0;
  logic [15:0] temp_in = '0;
  logic        wr_en = 1'b0, wr_unlock = 1'b0, wr_sel = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [6:0]  mod_idx;
  logic [5:0]  te_idx;
  logic [7:0]  mod_val, te_val;
  logic        out_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  int mod_tab [72];
  int te_tab  [36];
  // model pipeline: p_* = fetch in flight, e_* = expected outputs
  bit p_v, e_v;
  int p_mi, p_ti, p_mv, p_tv;
  int e_mi, e_ti, e_mv, e_tv;

  always #10 clk = ~clk;

  tlut_addr_gen uut (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .temp_in(temp_in),
    .wr_en(wr_en), .wr_unlock(wr_unlock), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .mod_idx(mod_idx), .te_idx(te_idx), .mod_val(mod_val), .te_val(te_val),
    .out_valid(out_valid)
  );

  function automatic int ref_idx(int t, int shift, int depth);
    int w = t >>> 8;
    int d = w + 40;
    if (d < 0) return 0;
    if ((d >> shift) > depth - 1) return depth - 1;
    return d >> shift;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R5", "out_valid", out_valid, e_v);
    check(e_v ? "R1 R3 R4" : "R9", "mod_idx", mod_idx, e_mi);
    check(e_v ? "R2 R3 R4" : "R9", "te_idx", te_idx, e_ti);
    check(e_v ? "R6 R7 R8" : "R9", "mod_val", mod_val, e_mv);
    check(e_v ? "R6 R7 R8" : "R9", "te_val", te_val, e_tv);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(bit stb, int t, bit we, bit unl, bit sel, int addr, int data);
    sample_stb = stb; temp_in = 16'(t);
    wr_en = we; wr_unlock = unl; wr_sel = sel;
    wr_addr = 7'(addr); wr_data = 8'(data);
    @(posedge clk);
    e_v = p_v;
    if (p_v) begin e_mi = p_mi; e_ti = p_ti; e_mv = p_mv; e_tv = p_tv; end
    p_v = stb;
    if (stb) begin
      p_mi = ref_idx(t, 1, 72); p_ti = ref_idx(t, 2, 36);
      p_mv = mod_tab[p_mi]; p_tv = te_tab[p_ti];
    end
    if (we && unl) begin
      if (!sel && addr < 72) mod_tab[addr] = data & 255;
      if (sel && addr < 36)  te_tab[addr]  = data & 255;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic sample(int t);
    tick(1, t, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    p_v = 0; e_v = 0;
    e_mi = 0; e_ti = 0; e_mv = 0; e_tv = 0;
    repeat (3) @(negedge clk);
    // R10: outputs cleared in reset
    compare();
    rst = 1'b0;
    idle(2);

    // R7: load both tables with access granted
    for (int i = 0; i < 72; i++) tick(0, 0, 1, 1, 0, i, (i * 3 + 1) & 255);
    for (int i = 0; i < 36; i++) tick(0, 0, 1, 1, 1, i, 8'hA0 ^ i);
    idle(2);

    // R7: locked writes must not land (entries 5 and 2 at -30 C)
    tick(0, 0, 1, 0, 0, 5, 8'hEE);
    tick(0, 0, 1, 0, 1, 2, 8'hEE);
    sample(-30 * 256);
    idle(3);

    // R8: write in the strobe cycle and the cycle after is not seen
    tick(1, -20 * 256, 1, 1, 0, 10, 8'h55);
    tick(0, 0, 1, 1, 1, 5, 8'h66);
    idle(2);
    sample(-20 * 256);   // now sees both new values
    idle(3);

    // R3, R4, R1, R2: window edges and range limits
    sample(-32768); sample(-41 * 256); sample(-40 * 256 - 1);
    sample(-40 * 256); sample(-39 * 256 + 255); sample(-38 * 256);
    sample(-36 * 256 - 1); sample(-36 * 256);
    sample(99 * 256 + 255); sample(100 * 256); sample(101 * 256);
    sample(102 * 256); sample(103 * 256 + 255); sample(104 * 256);
    sample(32767);
    idle(3);

    // R1 R2 R5 R6: sweep -60..120 C, back to back then spaced
    for (int t = -60 * 256; t <= 120 * 256; t += 64) sample(t);
    idle(2);
    for (int t = -60 * 256; t <= 120 * 256; t += 1000) begin
      sample(t);
      idle(t & 1);
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule